// File: doc/BRIEF.md
# Serial Register Port with Coherent Time Snapshot

This block is the two-wire serial target that gives a host access to a 17-byte register space numbered 00h to 10h. It samples the serial clock and data lines with the system clock. It recognises start, repeated start and stop conditions and answers its own 7-bit device address. Data lines are driven only through an active-high pull-down enable.

A write transfer starts with the address byte. The first data byte after it loads the register pointer. Every further data byte is handed to the register file as a one-cycle write strobe, and the pointer then advances. A read transfer returns bytes starting at the stored pointer, which is kept from one transfer to the next. The pointer advances after every byte sent. Past the last register the pointer folds back to 00h.

The seven time bytes (00h to 06h) are read from shadow copies of the live time inputs. Those copies are refreshed on every start, every stop and every pointer fold, so a multi-byte read sees one consistent time. A serial clock held low for too long returns the port to idle.

Top module: `rtc_i2c_target`

## Requirements
- R1: After reset the pointer (`rd_addr`) is 00h, `sda_oe` is 0 and `wr_en` is 0.
- R2: An address byte whose upper seven bits equal 1101000 is acknowledged by pulling SDA low during the ninth clock. Bit 0 of that byte selects the direction: 0 for write, 1 for read.
- R3: In a write transfer, the first data byte sets the pointer from its low five bits. Each later data byte is acknowledged and produces one cycle of `wr_en`, with `wr_addr` equal to the pointer and `wr_data` equal to the byte. In that same cycle `rd_addr` already shows the advanced pointer.
- R4: The pointer advances to 00h from 10h (or from any higher value) and otherwise adds one.
- R5: An address byte with a different device address gets no acknowledge. The bus is then ignored until the next start or stop: no strobe is issued and the pointer is unchanged.
- R6: On every start and every stop, all seven time bytes from `live_time` (byte i at bits 8i+7..8i) are copied into shadow registers. Reads of 00h to 06h return the shadow copy, and later changes of `live_time` do not show until the next copy.
- R7: When the pointer folds back to 00h, the shadow copies are refreshed at that moment.
- R8: A read returns bytes MSB first, starting at the stored pointer and advancing after each byte. Bytes at 07h and above come from `rd_data` for `rd_addr`. After a master NACK, SDA is released and stays released until the next start or stop. SDA changes only while SCL is low.
- R9: A repeated start, without a stop in between, is accepted as the beginning of a new transfer, and the pointer written before it is kept.
- R10: If SCL stays low for TIMEOUT_CYC system-clock cycles during a transfer, the port releases SDA and goes idle. It then ignores clock pulses until a fresh start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| rd_addr | output | 5 | Current register pointer, read address to the register file |
| rd_data | input | 8 | Register file byte at `rd_addr` (used for 07h and up) |
| live_time | input | 56 | Seven running time bytes, byte i at bits 8i+7..8i |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | 5 | Register written |
| wr_data | output | 8 | Byte written |

## Verification
Each line passes two synchronizer flops and one edge register, and the state register sits behind those. The port therefore reacts to an SCL fall about four system cycles later. It drives or releases SDA, and raises `wr_en` for one cycle, at that point. The bench changes its own SDA 20 ns after each SCL fall. It samples the acknowledge and read bits 50 ns into the SCL high phase, well after the port has settled and before the next fall. Strobes are logged on every clock and compared after the transfer. The stall test holds SCL low for longer than the timeout plus the synchronizer delay before it sends further bits.

// File: rtl/rtc_i2c_target.sv
`timescale 1ns/1ps
module rtc_i2c_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         LAST_REG    = 16,
  parameter int         SNAP_N      = 7,
  parameter int         TIMEOUT_CYC = 3500000,
  localparam int        AW          = $clog2(LAST_REG + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe,
  output logic [AW-1:0]       rd_addr,
  input  logic [7:0]          rd_data,
  input  logic [8*SNAP_N-1:0] live_time,
  output logic                wr_en,
  output logic [AW-1:0]       wr_addr,
  output logic [7:0]          wr_data
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK, S_SKIP} st_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_t;

  st_t           st;
  kind_t         kind;
  logic [1:0]    scl_q, sda_q;
  logic          scl_p, sda_p;
  logic [3:0]    bitcnt;
  logic [7:0]    sh, tx, rd_sel;
  logic          rnw, more;
  logic [AW-1:0] ptr, ptr_nxt;
  logic [TW-1:0] tcnt;
  logic [7:0]    shadow [SNAP_N];

  wire scl_s   = scl_q[1];
  wire sda_s   = sda_q[1];
  wire start_c = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  wire rise    = scl_s & ~scl_p;
  wire fall    = ~scl_s & scl_p;
  wire stall   = (tcnt == TW'(TIMEOUT_CYC));
  wire wrap    = (ptr >= AW'(LAST_REG));

  wire byte_in  = (st == S_RX) && fall && (bitcnt == 4'd8);
  wire adv_wr   = byte_in && (kind == K_DATA);
  wire adv_rd   = (st == S_TX) && fall && (bitcnt == 4'd7);
  wire snap     = start_c | stop_c | ((adv_wr | adv_rd) & wrap);

  assign ptr_nxt = wrap ? '0 : ptr + 1'b1;
  assign rd_addr = ptr;
  assign sda_oe  = (st == S_RXACK) | ((st == S_TX) & ~tx[7]);

  always_comb begin
    rd_sel = rd_data;
    for (int i = 0; i < SNAP_N; i++)
      if (ptr == AW'(i)) rd_sel = shadow[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      tcnt <= '0;
    else if (scl_s || st == S_IDLE)  tcnt <= '0;
    else if (!stall)                 tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SNAP_N; i++) shadow[i] <= '0;
    end else if (snap) begin
      for (int i = 0; i < SNAP_N; i++) shadow[i] <= live_time[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind    <= K_ADDR;
      bitcnt  <= '0;
      sh      <= '0;
      tx      <= 8'hFF;
      rnw     <= 1'b0;
      more    <= 1'b0;
      ptr     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stall) begin
        st <= S_IDLE;
      end else if (start_c) begin
        st     <= S_RX;
        kind   <= K_ADDR;
        bitcnt <= '0;
      end else if (stop_c) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_RX: begin
            if (rise && bitcnt < 4'd8) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_in) begin
              bitcnt <= '0;
              case (kind)
                K_ADDR: begin
                  if (sh[7:1] == DEV_ADDR) begin
                    st  <= S_RXACK;
                    rnw <= sh[0];
                  end else begin
                    st <= S_SKIP;
                  end
                end
                K_PTR: begin
                  st  <= S_RXACK;
                  ptr <= sh[AW-1:0];
                end
                default: begin
                  st      <= S_RXACK;
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= sh;
                  ptr     <= ptr_nxt;
                end
              endcase
            end
          end
          S_RXACK: begin
            if (fall) begin
              if (kind == K_ADDR && rnw) begin
                st     <= S_TX;
                tx     <= rd_sel;
                bitcnt <= '0;
              end else begin
                st   <= S_RX;
                kind <= (kind == K_ADDR) ? K_PTR : K_DATA;
              end
            end
          end
          S_TX: begin
            if (adv_rd) begin
              st  <= S_TXACK;
              ptr <= ptr_nxt;
              tx  <= 8'hFF;
            end else if (fall) begin
              tx     <= {tx[6:0], 1'b1};
              bitcnt <= bitcnt + 1'b1;
            end
          end
          S_TXACK: begin
            if (rise) begin
              more <= ~sda_s;
            end else if (fall) begin
              if (more) begin
                st     <= S_TX;
                tx     <= rd_sel;
                bitcnt <= '0;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module rtc_i2c_target_chk #(
  parameter int AW   = 5,
  parameter int LAST = 16,
  parameter int TMO  = 400
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] rd_addr
);
  int low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             low_cnt <= 0;
    else if (scl_i)         low_cnt <= 0;
    else if (low_cnt < TMO + 8) low_cnt <= low_cnt + 1;
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en); // R3
  AST_STROBE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !scl_i); // R3
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (rd_addr == ((wr_addr >= AW'(LAST)) ? '0 : wr_addr + 1'b1))); // R4
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i); // R8
  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (low_cnt >= TMO + 6) |-> !sda_oe); // R10
endmodule

bind rtc_i2c_target rtc_i2c_target_chk #(.AW(AW), .LAST(LAST_REG), .TMO(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr)
);

// File: tb/test_rtc_i2c_target.sv
`timescale 1ns/1ps
module test_rtc_i2c_target;
  localparam int TMO = 400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe, wr_en;
  logic [4:0] rd_addr, wr_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] live [0:6];
  logic [55:0] live_flat;
  logic [7:0] regs [0:31];
  logic [4:0] log_a [0:63];
  logic [7:0] log_d [0:63];
  int nlog, nchk, nfail;
  bit done;

  wire sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  always_comb for (int i = 0; i < 7; i++) live_flat[8*i +: 8] = live[i];
  assign rd_data = regs[rd_addr];

  rtc_i2c_target #(.TIMEOUT_CYC(TMO)) i_rtc_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .rd_addr(rd_addr), .rd_data(rd_data), .live_time(live_flat),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) regs[i] <= 8'hC0 + 8'(i);
      nlog <= 0;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
      log_a[nlog[5:0]] <= wr_addr;
      log_d[nlog[5:0]] <= wr_data;
      nlog <= nlog + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    #20 sda_m = 1'b1; #80 scl_m = 1'b1; #100 sda_m = 1'b0; #100 scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    #20 sda_m = 1'b0; #80 scl_m = 1'b1; #100 sda_m = 1'b1; #100;
  endtask

  task automatic send_bit(input logic b);
    #20 sda_m = b; #80 scl_m = 1'b1; #100 scl_m = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    #20 sda_m = 1'b1; #80 scl_m = 1'b1; #50 ack = ~sda_line; #50 scl_m = 1'b0;
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      #20 sda_m = 1'b1; #80 scl_m = 1'b1; #50 b[i] = sda_line; #50 scl_m = 1'b0;
    end
    #20 sda_m = nack; #80 scl_m = 1'b1; #100 scl_m = 1'b0; #20 sda_m = 1'b1;
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda_oe", 32'(sda_oe), 0);
    chk(wr_en == 1'b0, "R1 wr_en", 32'(wr_en), 0);
    chk(rd_addr == 5'd0, "R1 pointer", 32'(rd_addr), 0);
  endtask

  task automatic t_write();
    logic a; int base;
    base = nlog;
    bus_start();
    wbyte(8'hD0, a); chk(a, "R2 address ack", 32'(a), 1);
    wbyte(8'h08, a); chk(a, "R3 pointer ack", 32'(a), 1);
    wbyte(8'h11, a); chk(a, "R3 data ack", 32'(a), 1);
    wbyte(8'h22, a); chk(a, "R3 data ack", 32'(a), 1);
    bus_stop();
    chk(nlog == base + 2, "R3 strobe count", 32'(nlog - base), 2);
    chk(log_a[base] == 5'h08 && log_d[base] == 8'h11, "R3 first strobe", {log_a[base], log_d[base]}, {5'h08, 8'h11});
    chk(log_a[base+1] == 5'h09 && log_d[base+1] == 8'h22, "R3 second strobe", {log_a[base+1], log_d[base+1]}, {5'h09, 8'h22});
    chk(rd_addr == 5'h0A, "R3 pointer after write", 32'(rd_addr), 32'h0A);
  endtask

  task automatic t_wrap_write();
    logic a; int base;
    base = nlog;
    bus_start();
    wbyte(8'hD0, a); wbyte(8'h10, a); wbyte(8'hAA, a); wbyte(8'hBB, a);
    bus_stop();
    chk(log_a[base] == 5'h10 && log_d[base] == 8'hAA, "R4 strobe at 10h", {log_a[base], log_d[base]}, {5'h10, 8'hAA});
    chk(log_a[base+1] == 5'h00 && log_d[base+1] == 8'hBB, "R4 strobe after fold", {log_a[base+1], log_d[base+1]}, {5'h00, 8'hBB});
    chk(rd_addr == 5'h01, "R4 pointer after fold", 32'(rd_addr), 1);
  endtask

  task automatic t_foreign();
    logic a; int base;
    base = nlog;
    bus_start();
    wbyte(8'hA0, a); chk(!a, "R5 no ack foreign address", 32'(a), 0);
    wbyte(8'h05, a); chk(!a, "R5 no ack after foreign", 32'(a), 0);
    wbyte(8'h66, a);
    bus_stop();
    chk(nlog == base, "R5 no strobe", 32'(nlog - base), 0);
    chk(rd_addr == 5'h01, "R5 pointer kept", 32'(rd_addr), 1);
  endtask

  task automatic t_read_cur();
    logic a; logic [7:0] b;
    live[1] = 8'h21;
    bus_start();
    live[2] = 8'h99;
    wbyte(8'hD1, a); chk(a, "R2 read address ack", 32'(a), 1);
    rbyte(1'b0, b); chk(b == 8'h21, "R6 start snapshot byte 01h", 32'(b), 32'h21);
    rbyte(1'b1, b); chk(b == 8'h30, "R6 shadow holds byte 02h", 32'(b), 32'h30);
    repeat (8) @(posedge clk);
    #1 chk(sda_oe == 1'b0, "R8 released after NACK", 32'(sda_oe), 0);
    bus_stop();
    chk(rd_addr == 5'h03, "R8 pointer advanced", 32'(rd_addr), 3);
  endtask

  task automatic t_rstart_wrap();
    logic a; logic [7:0] b;
    bus_start();
    wbyte(8'hD0, a); wbyte(8'h0F, a);
    bus_start();
    live[0] = 8'h45;
    wbyte(8'hD1, a); chk(a, "R9 ack after repeated start", 32'(a), 1);
    rbyte(1'b0, b); chk(b == 8'hCF, "R9 read at written pointer", 32'(b), 32'hCF);
    rbyte(1'b0, b); chk(b == 8'hAA, "R8 read 10h", 32'(b), 32'hAA);
    rbyte(1'b1, b); chk(b == 8'h45, "R7 fold snapshot 00h", 32'(b), 32'h45);
    bus_stop();
  endtask

  task automatic t_stall();
    logic a; int base;
    bus_start();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    #20 sda_m = 1'b1;
    #((TMO + 200) * 10);
    chk(sda_oe == 1'b0, "R10 released in stall", 32'(sda_oe), 0);
    send_bit(1'b1);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    #20 sda_m = 1'b1; #80 scl_m = 1'b1; #50 a = ~sda_line; #50 scl_m = 1'b0;
    chk(!a, "R10 no ack without fresh start", 32'(a), 0);
    bus_stop();
    base = nlog;
    bus_start();
    wbyte(8'hD0, a); chk(a, "R10 ack after fresh start", 32'(a), 1);
    wbyte(8'h02, a); wbyte(8'h5A, a);
    bus_stop();
    chk(nlog == base + 1 && log_a[base] == 5'h02 && log_d[base] == 8'h5A, "R10 write after recovery",
        {log_a[base], log_d[base]}, {5'h02, 8'h5A});
  endtask

  initial begin
    for (int i = 0; i < 7; i++) live[i] = 8'h10 * 8'(i + 1);
    nchk = 0; nfail = 0; done = 1'b0;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 t_reset();
    t_write();
    t_wrap_write();
    t_foreign();
    t_read_cur();
    t_rstart_wrap();
    t_stall();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end
endmodule